// File: doc/BRIEF.md
# IrDA SIR Receive Byte Destuffer

This block sits behind the UART deserializer of an asynchronous infrared link and rebuilds frame content from the raw byte stream. It waits for a begin flag and then passes every payload byte to two destinations: a receive FIFO write stream and a CRC checker feed. While it does so, it strips transparency escapes and restores the bit that the transmitter inverted. The payload covers address, control, information and CRC bytes.

An escape byte followed at once by an unescaped end flag is an abort. The block reports it on its own status pulse and produces no end-of-frame for it. A begin flag that arrives inside a frame restarts the frame and flags a framing error. Bytes that arrive outside a frame, other than the begin flag, are dropped. The CRC arithmetic and the FIFO storage are left to neighbouring blocks.

Top module: `irsir_rx_destuff`

## Requirements
- R1: After reset, all outputs are low and the block is hunting for a begin flag.
- R2: While hunting, any accepted byte other than the begin flag (0xC0) produces no data output and no status pulse.
- R3: An accepted 0xC0 while hunting pulses `frame_start` and enters the frame.
- R4: Inside a frame, an unescaped byte other than 0xC0, 0xC1 or 0x7D appears unchanged on both `fifo_data` and `crc_data`, with `fifo_valid` and `crc_valid` high for one cycle.
- R5: Inside a frame, an unescaped 0x7D is discarded: no valid is raised for it.
- R6: A byte that follows an escape, other than 0xC0 or 0xC1, is output on both streams with bit 5 inverted (XOR 0x20).
- R7: An escape followed by 0xC1 pulses `frame_abort`, raises no `frame_end`, and returns to hunting.
- R8: An unescaped 0xC1 inside a frame pulses `frame_end` and returns to hunting.
- R9: A 0xC0 inside a frame, escaped or not, pulses `frame_start` and `frame_error` together, keeps the frame open, and clears any pending escape.
- R10: The pending escape applies to exactly the next accepted byte, and idle cycles without `rx_stb` do not clear it.
- R11: All results for a byte accepted on one clock edge are visible for exactly the following cycle, with the default registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | BYTE_W | Raw byte from the deserializer |
| fifo_valid | output | 1 | Write strobe toward the receive FIFO |
| fifo_data | output | BYTE_W | Restored byte for the FIFO |
| crc_valid | output | 1 | Byte strobe toward the CRC checker |
| crc_data | output | BYTE_W | Restored byte for the CRC checker |
| frame_start | output | 1 | Begin flag accepted (pulse) |
| frame_end | output | 1 | Frame closed by end flag (pulse) |
| frame_abort | output | 1 | Abort pair seen (pulse) |
| frame_error | output | 1 | Begin flag arrived inside an open frame (pulse) |

## Verification
The default build has one output register. Every data and status result for a byte therefore shows up in the cycle after the edge that accepted it, and it lasts one cycle. Each scenario task drives a byte half a period before an edge and drops the strobe on the next falling edge. It samples all outputs at that same falling edge, which is exactly the one-cycle window in which they are due. The escape-across-idle case inserts strobe-free cycles first and then applies the same sampling.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
   typedef enum logic [1:0] {
      K_DATA = 2'd0,
      K_BOF  = 2'd1,
      K_EOF  = 2'd2,
      K_ESC  = 2'd3
   } byte_kind_t;

   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_FRAME = 1'b1
   } rx_state_t;

   typedef struct packed {
      logic sof;
      logic eof;
      logic abt;
      logic ferr;
   } rx_evt_t;
endpackage

// File: rtl/irsir_classify.sv
module irsir_classify #(
   parameter int unsigned    BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] BOF_CODE = 8'hC0,
   parameter logic [BYTE_W-1:0] EOF_CODE = 8'hC1,
   parameter logic [BYTE_W-1:0] ESC_CODE = 8'h7D
) (
   input  logic [BYTE_W-1:0] byte_i,
   output irsir_pkg::byte_kind_t kind_o
);
   import irsir_pkg::*;

   always_comb begin
      if (byte_i == BOF_CODE)      kind_o = K_BOF;
      else if (byte_i == EOF_CODE) kind_o = K_EOF;
      else if (byte_i == ESC_CODE) kind_o = K_ESC;
      else                         kind_o = K_DATA;
   end
endmodule

// File: rtl/irsir_frame_fsm.sv
module irsir_frame_fsm #(
   parameter int unsigned       BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] FLIP_MASK = 8'h20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stb_i,
   input  logic [BYTE_W-1:0]     byte_i,
   input  irsir_pkg::byte_kind_t kind_i,
   output logic                  emit_o,
   output logic [BYTE_W-1:0]     data_o,
   output irsir_pkg::rx_evt_t    evt_o,
   output logic                  in_frame_o,
   output logic                  esc_o
);
   import irsir_pkg::*;

   rx_state_t state_q, state_d;
   logic      esc_q, esc_d;

   always_comb begin
      state_d = state_q;
      esc_d   = esc_q;
      emit_o  = 1'b0;
      data_o  = byte_i;
      evt_o   = '0;
      if (stb_i) begin
         unique case (state_q)
            ST_HUNT: begin
               if (kind_i == K_BOF) begin
                  state_d   = ST_FRAME;
                  esc_d     = 1'b0;
                  evt_o.sof = 1'b1;
               end
            end
            ST_FRAME: begin
               if (kind_i == K_BOF) begin
                  esc_d      = 1'b0;
                  evt_o.sof  = 1'b1;
                  evt_o.ferr = 1'b1;
               end else if (esc_q) begin
                  esc_d = 1'b0;
                  if (kind_i == K_EOF) begin
                     evt_o.abt = 1'b1;
                     state_d   = ST_HUNT;
                  end else begin
                     emit_o = 1'b1;
                     data_o = byte_i ^ FLIP_MASK;
                  end
               end else begin
                  unique case (kind_i)
                     K_EOF: begin
                        evt_o.eof = 1'b1;
                        state_d   = ST_HUNT;
                     end
                     K_ESC:   esc_d  = 1'b1;
                     default: emit_o = 1'b1;
                  endcase
               end
            end
            default: state_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         esc_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         esc_q   <= esc_d;
      end
   end

   assign in_frame_o = (state_q == ST_FRAME);
   assign esc_o      = esc_q;
endmodule

// File: rtl/irsir_out_stage.sv
module irsir_out_stage #(
   parameter int unsigned BYTE_W  = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               emit_i,
   input  logic [BYTE_W-1:0]  data_i,
   input  irsir_pkg::rx_evt_t evt_i,
   output logic               emit_o,
   output logic [BYTE_W-1:0]  data_o,
   output irsir_pkg::rx_evt_t evt_o
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               emit_o <= 1'b0;
               data_o <= '0;
               evt_o  <= '0;
            end else begin
               emit_o <= emit_i;
               data_o <= emit_i ? data_i : '0;
               evt_o  <= evt_i;
            end
         end
      end else begin : g_comb
         assign emit_o = emit_i;
         assign data_o = emit_i ? data_i : '0;
         assign evt_o  = evt_i;
      end
   endgenerate
endmodule

// File: rtl/irsir_rx_destuff.sv
module irsir_rx_destuff #(
   parameter int unsigned       BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] BOF_CODE  = 8'hC0,
   parameter logic [BYTE_W-1:0] EOF_CODE  = 8'hC1,
   parameter logic [BYTE_W-1:0] ESC_CODE  = 8'h7D,
   parameter logic [BYTE_W-1:0] FLIP_MASK = 8'h20,
   parameter bit                OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_stb,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              fifo_valid,
   output logic [BYTE_W-1:0] fifo_data,
   output logic              crc_valid,
   output logic [BYTE_W-1:0] crc_data,
   output logic              frame_start,
   output logic              frame_end,
   output logic              frame_abort,
   output logic              frame_error
);
   import irsir_pkg::*;

   if (BYTE_W < 2) begin : g_bad_width
      $error("BYTE_W must be at least 2");
   end
   if (BOF_CODE == EOF_CODE || BOF_CODE == ESC_CODE || EOF_CODE == ESC_CODE) begin : g_bad_codes
      $error("flag and escape codes must be distinct");
   end
   if (FLIP_MASK == '0) begin : g_bad_mask
      $error("FLIP_MASK must be nonzero");
   end

   byte_kind_t        kind;
   logic              emit;
   logic [BYTE_W-1:0] emit_data;
   rx_evt_t           evt;
   rx_evt_t           evt_out;
   logic              emit_out;
   logic [BYTE_W-1:0] data_out;
   logic              in_frame;
   logic              esc_pend;

   irsir_classify #(
      .BYTE_W(BYTE_W), .BOF_CODE(BOF_CODE), .EOF_CODE(EOF_CODE), .ESC_CODE(ESC_CODE)
   ) u_classify (
      .byte_i(rx_byte),
      .kind_o(kind)
   );

   irsir_frame_fsm #(
      .BYTE_W(BYTE_W), .FLIP_MASK(FLIP_MASK)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .stb_i(rx_stb), .byte_i(rx_byte), .kind_i(kind),
      .emit_o(emit), .data_o(emit_data), .evt_o(evt),
      .in_frame_o(in_frame), .esc_o(esc_pend)
   );

   irsir_out_stage #(
      .BYTE_W(BYTE_W), .OUT_REG(OUT_REG)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .emit_i(emit), .data_i(emit_data), .evt_i(evt),
      .emit_o(emit_out), .data_o(data_out), .evt_o(evt_out)
   );

   assign fifo_valid  = emit_out;
   assign fifo_data   = data_out;
   assign crc_valid   = emit_out;
   assign crc_data    = data_out;
   assign frame_start = evt_out.sof;
   assign frame_end   = evt_out.eof;
   assign frame_abort = evt_out.abt;
   assign frame_error = evt_out.ferr;

   if (OUT_REG) begin : g_chk
      AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         rx_stb && !in_frame && rx_byte != BOF_CODE |=> !fifo_valid && !frame_start); // R2
      AST_ESC_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
         rx_stb && in_frame && !esc_pend && rx_byte == ESC_CODE |=> !fifo_valid && !crc_valid); // R5
      AST_UNESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
         rx_stb && in_frame && esc_pend && rx_byte != EOF_CODE && rx_byte != BOF_CODE
         |=> fifo_valid && fifo_data == ($past(rx_byte) ^ FLIP_MASK)); // R6
      AST_ABORT_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
         frame_abort |-> !frame_end); // R7
      AST_ABORT_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
         rx_stb && in_frame && esc_pend && rx_byte == EOF_CODE |=> !in_frame && frame_abort); // R7
      AST_ESC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         rx_stb && esc_pend |=> !esc_pend); // R10
      AST_ESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !rx_stb && esc_pend |=> esc_pend); // R10
   end
endmodule

// File: tb/irsir_rx_destuff_tb_top.sv
module irsir_rx_destuff_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_stb = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       fifo_valid, crc_valid, frame_start, frame_end, frame_abort, frame_error;
   logic [7:0] fifo_data, crc_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   irsir_rx_destuff dut_i (
      .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_byte(rx_byte),
      .fifo_valid(fifo_valid), .fifo_data(fifo_data),
      .crc_valid(crc_valid), .crc_data(crc_data),
      .frame_start(frame_start), .frame_end(frame_end),
      .frame_abort(frame_abort), .frame_error(frame_error)
   );

   // captured outputs: {valid, crc_valid, sof, eof, abt, ferr}
   logic [5:0] cap_f;
   logic [7:0] cap_d, cap_c;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_stb  = 1'b1;
      rx_byte = b;
      @(negedge clk);
      rx_stb  = 1'b0;
      cap_f = {fifo_valid, crc_valid, frame_start, frame_end, frame_abort, frame_error};
      cap_d = fifo_data;
      cap_c = crc_data;
   endtask

   task automatic expect_data(input string req, input logic [7:0] b, input logic [7:0] exp);
      send(b);
      chk(req, {cap_f, cap_d, cap_c}, {6'b110000, exp, exp});
   endtask

   task automatic expect_flags(input string req, input logic [7:0] b, input logic [5:0] exp);
      send(b);
      chk(req, {26'd0, cap_f}, {26'd0, exp});
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 reset outputs", {fifo_valid, crc_valid, frame_start, frame_end, frame_abort, frame_error},
          6'b0);
      expect_flags("R1 hunting after reset", 8'h41, 6'b0);
   endtask

   task automatic t_hunt_ignore;
      expect_flags("R2 hunt ignores data", 8'h12, 6'b0);
      expect_flags("R2 hunt ignores escape", 8'h7D, 6'b0);
      expect_flags("R2 hunt ignores end flag", 8'hC1, 6'b0);
   endtask

   task automatic t_normal_frame;
      expect_flags("R3 begin flag", 8'hC0, 6'b001000);
      expect_data("R4 address byte", 8'hFF, 8'hFF);
      expect_data("R4 control byte", 8'h3F, 8'h3F);
      expect_data("R4 info byte", 8'h00, 8'h00);
      expect_flags("R8 end flag", 8'hC1, 6'b000100);
      expect_flags("R8 back to hunt", 8'h55, 6'b0);
   endtask

   task automatic t_escapes;
      expect_flags("R3 begin flag", 8'hC0, 6'b001000);
      expect_flags("R5 escape dropped", 8'h7D, 6'b0);
      expect_data("R6 escaped begin code", 8'hE0, 8'hC0);
      expect_flags("R5 escape dropped", 8'h7D, 6'b0);
      expect_data("R6 escaped end code", 8'hE1, 8'hC1);
      expect_flags("R5 escape dropped", 8'h7D, 6'b0);
      expect_data("R6 escaped escape code", 8'h5D, 8'h7D);
      expect_data("R10 escape cleared", 8'h41, 8'h41);
      expect_flags("R5 escape dropped", 8'h7D, 6'b0);
      expect_data("R10 double escape", 8'h7D, 8'h5D);
      expect_data("R10 cleared after double", 8'h20, 8'h20);
      expect_flags("R5 escape before gap", 8'h7D, 6'b0);
      repeat (4) @(negedge clk);
      expect_data("R10 escape survives idle", 8'h61, 8'h41);
      expect_flags("R8 end flag", 8'hC1, 6'b000100);
   endtask

   task automatic t_abort;
      expect_flags("R3 begin flag", 8'hC0, 6'b001000);
      expect_data("R4 byte", 8'h99, 8'h99);
      expect_flags("R5 escape dropped", 8'h7D, 6'b0);
      expect_flags("R7 abort pulse no end", 8'hC1, 6'b000010);
      expect_flags("R7 hunting after abort", 8'h33, 6'b0);
      expect_flags("R7 end flag ignored after abort", 8'hC1, 6'b0);
   endtask

   task automatic t_restart;
      expect_flags("R3 begin flag", 8'hC0, 6'b001000);
      expect_data("R4 byte", 8'h10, 8'h10);
      expect_flags("R9 restart in frame", 8'hC0, 6'b001001);
      expect_data("R9 frame stays open", 8'h11, 8'h11);
      expect_flags("R5 escape dropped", 8'h7D, 6'b0);
      expect_flags("R9 escaped begin restarts", 8'hC0, 6'b001001);
      expect_data("R9 escape flushed", 8'h41, 8'h41);
      expect_flags("R8 end flag", 8'hC1, 6'b000100);
   endtask

   task automatic t_one_cycle;
      expect_flags("R3 begin flag", 8'hC0, 6'b001000);
      send(8'h77);
      @(negedge clk);
      chk("R11 valid lasts one cycle", {31'd0, fifo_valid}, 32'd0);
      expect_flags("R8 end flag", 8'hC1, 6'b000100);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_hunt_ignore();
            t_normal_frame();
            t_escapes();
            t_abort();
            t_restart();
            t_one_cycle();
         end
         begin
            repeat (20000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule